// File: doc/BRIEF.md
# Quadrant-Multiplexed Almost-Full Flag Scanner

This block sends the almost-full status of a bank of queues out on a narrow flag bus. The status flags of 32 queues are split into four quadrants of eight. One quadrant at a time is registered onto an 8-bit output bus on the rising edge of the write clock. Two ways of choosing the quadrant are supported. The mode is fixed while the block is out of reset.

In polled mode the quadrants are scanned in a ring of devices. A device that holds the scan token shows its quadrants 1, 2, 3 and 4 on four successive edges. A sync output marks the cycle in which quadrant 1 is on the bus. A token output pulses during the cycle in which quadrant 4 is on the bus. The token output of one device feeds the token input of the next, and the token output of the last device returns to the first. A device on its own feeds its token output back to its own token input. A device that does not hold the token drives all ones, which is the inactive flag level. The devices' buses can therefore be combined without a contention check.

In direct mode a strobe chooses a quadrant from two bits of the write address. The chosen quadrant stays on the bus, refreshed every edge, until the next accepted strobe. Strobes are refused until the programming-done input is high.

Top module: `afq_flag_scanner`

## Requirements
- R1: While reset is low, and on the first sample after reset, the flag bus is all ones and the sync and token outputs are low.
- R2: Quadrant k (k = 0 to 3, where 0 is quadrant 1) is the flag inputs [8k+7:8k]. Bit i of the bus carries queue 8k+i, as sampled at the edge that loads the quadrant.
- R3: In polled mode a device with the master input high loads quadrant 1 on the first edge after reset, then quadrants 2, 3 and 4 on the next three edges.
- R4: In polled mode the sync output is high exactly in the cycles in which quadrant 1 of this device is on the bus.
- R5: In polled mode the token output is high exactly in the cycles in which quadrant 4 of this device is on the bus, so it lasts one cycle.
- R6: A token input that is high at an edge in polled mode makes the device load quadrant 1 at that edge. A device whose token output is looped back to its own token input therefore repeats 1, 2, 3, 4 without a gap.
- R7: In polled mode a device that does not hold the token drives all ones. This covers a slave device before its first token, and a device at the edge after its quadrant 4 when no token arrives.
- R8: In direct mode, an edge at which the strobe and the programming-done input are both high selects the quadrant given by write-address bits [4:3], where 0 means quadrant 1. That quadrant is reloaded from the flag inputs on every edge until the next accepted strobe.
- R9: In direct mode a strobe is ignored while programming-done is low. Until the first accepted strobe after reset the bus stays all ones.
- R10: In direct mode the sync and token outputs stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_polled | input | 1 | 1 = polled ring scan, 0 = direct strobe selection; static out of reset |
| is_master | input | 1 | Polled mode: device owns the token after reset |
| flags_in | input | 32 | Almost-full flags, one per queue |
| strobe | input | 1 | Direct mode quadrant select strobe |
| wr_addr | input | 8 | Write address; bits [4:3] give the quadrant in direct mode |
| prog_done | input | 1 | High once device programming is complete |
| tok_in | input | 1 | Scan token from the previous device in the ring |
| flag_bus | output | 8 | Registered flags of the quadrant on the bus |
| sync_o | output | 1 | High while quadrant 1 of this device is on the bus |
| tok_out | output | 1 | Token pulse while quadrant 4 of this device is on the bus |

## Verification
The hardest situation to reach from the ports is the handoff between devices. The slave must put its quadrant 1 on the bus on exactly the edge that follows the master's quadrant 4, and the master must drop to all ones on that same edge. No single device shows this on its own. The bench wires two instances into a ring, runs them beside a self-looped single device, and applies fresh random flags at every edge, so that a scan that is late, early or stale shows up as a data mismatch. Direct mode is checked after a separate reset. The run starts with directed strobes while programming-done is low, then mixes random strobes, addresses and programming-done levels.

// File: rtl/afq_pkg.sv
// Package: afq_pkg
// Shared types for the flag scanner. Holds the scan-mode encoding used
// inside the top module. Assumes mode is static out of reset.
package afq_pkg;

    typedef enum logic {
        SCAN_DIRECT = 1'b0,
        SCAN_POLLED = 1'b1
    } scan_mode_e;

endpackage : afq_pkg

// File: rtl/afq_token_seq.sv
// Module: afq_token_seq
// Polled-mode quadrant sequencer. It tracks whether this device holds the
// scan token and which quadrant is on the bus. It gives the next-edge
// selection to the flag register and decodes the sync and token pulses
// from the current state.
// Assumptions: 'enable' is static out of reset. A high tok_in restarts the
// scan at quadrant 1 at that edge. A master loads quadrant 1 on the first
// enabled edge after reset.
module afq_token_seq #(
    parameter int NUM_QUADS = 4,
    parameter int QIDX_W    = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              is_master,
    input  logic              tok_in,
    output logic              nxt_hold,
    output logic [QIDX_W-1:0] nxt_idx,
    output logic              sync_o,
    output logic              tok_out
);

    localparam logic [QIDX_W-1:0] LAST_IDX  = QIDX_W'(NUM_QUADS - 1);
    localparam logic [QIDX_W-1:0] FIRST_IDX = '0;

    logic              hold_q;
    logic [QIDX_W-1:0] idx_q;
    logic              start_q;

    // Next-state: restart on a token or master start, else step, release after the last quadrant.
    always_comb begin
        nxt_hold = hold_q;
        nxt_idx  = idx_q;
        if (tok_in || start_q) begin
            nxt_hold = 1'b1;
            nxt_idx  = FIRST_IDX;
        end else if (hold_q) begin
            if (idx_q == LAST_IDX) begin
                nxt_hold = 1'b0;
                nxt_idx  = FIRST_IDX;
            end else begin
                nxt_idx = idx_q + 1'b1;
            end
        end
        if (!enable) begin
            nxt_hold = 1'b0;
            nxt_idx  = FIRST_IDX;
        end
    end

    // State register: holds the token flag, the quadrant index and the pending master start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            idx_q   <= FIRST_IDX;
            start_q <= is_master;
        end else if (enable) begin
            hold_q  <= nxt_hold;
            idx_q   <= nxt_idx;
            start_q <= 1'b0;
        end
    end

    // Output decode: sync on the first quadrant, token on the last.
    always_comb begin
        sync_o  = enable && hold_q && (idx_q == FIRST_IDX);
        tok_out = enable && hold_q && (idx_q == LAST_IDX);
    end

endmodule : afq_token_seq

// File: rtl/afq_direct_sel.sv
// Module: afq_direct_sel
// Direct-mode quadrant selection register. It accepts a strobe only when
// programming is done, takes the quadrant index from a field of the write
// address, and keeps that selection until the next accepted strobe.
// Assumptions: nothing is selected after reset, so the bus stays inactive
// until the first accepted strobe.
module afq_direct_sel #(
    parameter int ADDR_W   = 8,
    parameter int QSEL_LSB = 3,
    parameter int QIDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              strobe,
    input  logic              prog_done,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              nxt_valid,
    output logic [QIDX_W-1:0] nxt_idx
);

    logic              valid_q;
    logic [QIDX_W-1:0] idx_q;
    logic              take;

    // Strobe qualification: only in direct mode and only once programming is done.
    always_comb begin
        take      = enable && strobe && prog_done;
        nxt_valid = take ? 1'b1 : valid_q;
        nxt_idx   = take ? wr_addr[QSEL_LSB +: QIDX_W] : idx_q;
    end

    // Selection register: captures the address field on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            valid_q <= nxt_valid;
            idx_q   <= nxt_idx;
        end
    end

endmodule : afq_direct_sel

// File: rtl/afq_quad_mux.sv
// Module: afq_quad_mux
// Registered quadrant multiplexer. It cuts the flag vector into equal
// quadrants and on every edge loads the selected one into the output
// register, or all ones when nothing is selected.
// Assumptions: the flag vector width is QUAD_W * NUM_QUADS.
module afq_quad_mux #(
    parameter int QUAD_W    = 8,
    parameter int NUM_QUADS = 4,
    parameter int QIDX_W    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [QUAD_W*NUM_QUADS-1:0] flags_in,
    input  logic                        load_valid,
    input  logic [QIDX_W-1:0]           load_idx,
    output logic [QUAD_W-1:0]           flag_q
);

    logic [QUAD_W-1:0] quad_slice [NUM_QUADS];
    logic [QUAD_W-1:0] picked;

    // Slice the flag vector into quadrants.
    for (genvar q = 0; q < NUM_QUADS; q++) begin : g_slice
        assign quad_slice[q] = flags_in[q*QUAD_W +: QUAD_W];
    end

    // Quadrant pick: indexed selection; an index past the last quadrant reads inactive.
    always_comb begin
        picked = '1;
        for (int q = 0; q < NUM_QUADS; q++) begin
            if (load_idx == QIDX_W'(q)) picked = quad_slice[q];
        end
    end

    // Output register: the selected quadrant, or inactive ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '1;
        end else begin
            flag_q <= load_valid ? picked : '1;
        end
    end

endmodule : afq_quad_mux

// File: rtl/afq_flag_scanner.sv
// Module: afq_flag_scanner (top)
// Shows the almost-full flags of NUM_QUEUES queues one quadrant at a time
// on a QUAD_W-bit bus. In polled mode the token sequencer selects the
// quadrant; in direct mode the strobe-loaded register selects it.
// Assumptions: mode_polled and is_master are static out of reset. Tri-state
// control and flag generation lie outside this block.
module afq_flag_scanner #(
    parameter int NUM_QUEUES = 32,
    parameter int QUAD_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int QSEL_LSB   = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_polled,
    input  logic                  is_master,
    input  logic [NUM_QUEUES-1:0] flags_in,
    input  logic                  strobe,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  prog_done,
    input  logic                  tok_in,
    output logic [QUAD_W-1:0]     flag_bus,
    output logic                  sync_o,
    output logic                  tok_out
);

    import afq_pkg::*;

    localparam int NUM_QUADS = NUM_QUEUES / QUAD_W;
    localparam int QIDX_W    = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1;

    scan_mode_e        mode;
    logic              is_polled;
    logic              seq_hold;
    logic [QIDX_W-1:0] seq_idx;
    logic              dir_valid;
    logic [QIDX_W-1:0] dir_idx;
    logic              sel_valid;
    logic [QIDX_W-1:0] sel_idx;

    // Mode decode from the static mode pin.
    always_comb begin
        mode      = scan_mode_e'(mode_polled);
        is_polled = (mode == SCAN_POLLED);
    end

    afq_token_seq #(
        .NUM_QUADS (NUM_QUADS),
        .QIDX_W    (QIDX_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (is_polled),
        .is_master (is_master),
        .tok_in    (tok_in),
        .nxt_hold  (seq_hold),
        .nxt_idx   (seq_idx),
        .sync_o    (sync_o),
        .tok_out   (tok_out)
    );

    afq_direct_sel #(
        .ADDR_W   (ADDR_W),
        .QSEL_LSB (QSEL_LSB),
        .QIDX_W   (QIDX_W)
    ) dsel_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!is_polled),
        .strobe    (strobe),
        .prog_done (prog_done),
        .wr_addr   (wr_addr),
        .nxt_valid (dir_valid),
        .nxt_idx   (dir_idx)
    );

    // Source select: the polled sequencer or the direct register drives the next quadrant.
    always_comb begin
        sel_valid = is_polled ? seq_hold : dir_valid;
        sel_idx   = is_polled ? seq_idx  : dir_idx;
    end

    afq_quad_mux #(
        .QUAD_W    (QUAD_W),
        .NUM_QUADS (NUM_QUADS),
        .QIDX_W    (QIDX_W)
    ) mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_in   (flags_in[QUAD_W*NUM_QUADS-1:0]),
        .load_valid (sel_valid),
        .load_idx   (sel_idx),
        .flag_q     (flag_bus)
    );

endmodule : afq_flag_scanner

// File: rtl/afq_scanner_chk.sv
// Module: afq_scanner_chk
// Assertion checker for afq_flag_scanner, attached with bind. It checks
// the relations between the pulses and the handoff over time at the ports.
module afq_scanner_chk #(
    parameter int QUAD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_polled,
    input logic              tok_in,
    input logic [QUAD_W-1:0] flag_bus,
    input logic              sync_o,
    input logic              tok_out
);

    AST_TOK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out |=> !tok_out); // R5

    AST_SYNC_TOK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sync_o && tok_out)); // R4

    AST_SYNC_THEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |=> (!sync_o && !tok_out)); // R3

    AST_TOKEN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_polled && tok_in) |=> sync_o); // R6

    AST_RELEASE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_polled && tok_out && !tok_in) |=> (flag_bus == '1)); // R7

    AST_DIRECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_polled |-> (!sync_o && !tok_out)); // R10

endmodule : afq_scanner_chk

bind afq_flag_scanner afq_scanner_chk #(.QUAD_W(QUAD_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_polled (mode_polled),
    .tok_in      (tok_in),
    .flag_bus    (flag_bus),
    .sync_o      (sync_o),
    .tok_out     (tok_out)
);

// File: tb/afq_flag_scanner_tb_top.sv
// Bench: a two-device ring (dut_i master, peer_i slave) plus a self-looped
// single device, first in polled mode, then dut_i in direct mode.
module afq_flag_scanner_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_polled = 1'b1;
    logic [31:0] fa = '0, fb = '0, fs = '0;
    logic        strobe = 1'b0, prog_done = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  bus_a, bus_b, bus_s;
    logic        sync_a, sync_b, sync_s, tok_a, tok_b, tok_s;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    afq_flag_scanner dut_i (
        .clk(clk), .rst_n(rst_n), .mode_polled(mode_polled), .is_master(1'b1),
        .flags_in(fa), .strobe(strobe), .wr_addr(addr), .prog_done(prog_done),
        .tok_in(tok_b), .flag_bus(bus_a), .sync_o(sync_a), .tok_out(tok_a));

    afq_flag_scanner peer_i (
        .clk(clk), .rst_n(rst_n), .mode_polled(mode_polled), .is_master(1'b0),
        .flags_in(fb), .strobe(1'b0), .wr_addr(8'h00), .prog_done(prog_done),
        .tok_in(tok_a), .flag_bus(bus_b), .sync_o(sync_b), .tok_out(tok_b));

    afq_flag_scanner solo_i (
        .clk(clk), .rst_n(rst_n), .mode_polled(1'b1), .is_master(1'b1),
        .flags_in(fs), .strobe(1'b0), .wr_addr(8'h00), .prog_done(1'b1),
        .tok_in(tok_s), .flag_bus(bus_s), .sync_o(sync_s), .tok_out(tok_s));

    // Quadrant k of a flag word (quadrant 1 is k = 0).
    function automatic logic [7:0] quad(input logic [31:0] f, input int k);
        return f[k*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, pb, ps;
        logic        p_stb, p_pd, d_valid;
        logic [7:0]  p_addr;
        int          d_sel;
        void'($urandom(32'h5EED_0A1F));
        fa = $urandom; fb = $urandom; fs = $urandom;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bus_a", bus_a, 8'hFF); chk("R1 bus_b", bus_b, 8'hFF);
        chk("R1 sync_a", sync_a, 0);   chk("R1 tok_a", tok_a, 0);
        chk("R1 tok_b", tok_b, 0);
        pa = fa; pb = fb; ps = fs;
        rst_n = 1'b1;
        for (int n = 1; n <= 200; n++) begin
            int ph, p4;
            logic [7:0] ea, eb;
            @(negedge clk);
            ph = (n - 1) % 8;
            p4 = (n - 1) % 4;
            ea = (ph < 4)  ? quad(pa, ph)     : 8'hFF;
            eb = (ph >= 4) ? quad(pb, ph - 4) : 8'hFF;
            chk((n <= 4) ? "R3 master order" : "R2 R6 ring data A", bus_a, ea);
            chk((n <= 4) ? "R7 slave idle"   : "R6 R7 ring data B", bus_b, eb);
            chk("R4 sync A", sync_a, ph == 0);
            chk("R4 sync B", sync_b, ph == 4);
            chk("R5 token A", tok_a, ph == 3);
            chk("R5 token B", tok_b, ph == 7);
            chk("R6 loop data", bus_s, quad(ps, p4));
            chk("R6 loop sync/tok", {sync_s, tok_s}, {p4 == 0, p4 == 3});
            // Corner: all-zero and all-one flag words mixed with random ones.
            fa = (n % 17 == 0) ? 32'h0 : $urandom;
            fb = (n % 13 == 0) ? 32'hFFFF_FFFF : $urandom;
            fs = $urandom;
            pa = fa; pb = fb; ps = fs;
        end

        // Direct mode, after a fresh reset.
        @(negedge clk);
        rst_n = 1'b0; mode_polled = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 direct reset", bus_a, 8'hFF);
        rst_n = 1'b1;
        d_valid = 1'b0; d_sel = 0;
        strobe = 1'b1; prog_done = 1'b0; addr = 8'h18;
        p_stb = strobe; p_pd = prog_done; p_addr = addr; pa = fa;
        for (int n = 1; n <= 400; n++) begin
            @(negedge clk);
            if (p_stb && p_pd) begin
                d_valid = 1'b1;
                d_sel   = int'(p_addr[4:3]);
            end
            chk(d_valid ? "R8 direct data" : "R9 ignored strobe", bus_a,
                d_valid ? quad(pa, d_sel) : 8'hFF);
            chk("R10 quiet", {sync_a, tok_a}, 2'b00);
            chk("R10 peer", bus_b, 8'hFF);
            fa = $urandom;
            addr = 8'($urandom);
            if (n < 8) begin
                strobe = 1'b1; prog_done = 1'b0;
            end else begin
                strobe    = ($urandom % 4) == 0;
                prog_done = ($urandom % 5) != 0;
            end
            p_stb = strobe; p_pd = prog_done; p_addr = addr; pa = fa;
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule : afq_flag_scanner_tb_top